// File: doc/BRIEF.md
# IF Counter Window Discriminator

This block decides whether an intermediate-frequency signal sits close enough to a programmed centre frequency for a tuner to stop its station search. A squared and synchronised IF pulse stream is counted over a gate whose length comes from a programmable prescaler of the reference clock, followed by a power-of-two tick chain. When the gate closes, the block raises a one-cycle result strobe. Together with the strobe it updates a search/stop flag that says whether the measured count fell inside a tolerance window around the expected count.

The counting is done by a down-counter. At each gate start it is preloaded with the expected count plus half the window. At gate end the remaining value is judged against the window, so deviations on both sides are accepted symmetrically. The counter also tracks whether it went below zero. The expected count per base tick is a per-mode constant (FM, AM, AM up-conversion) plus a 5-bit centre offset. Controls are sampled continuously: any change restarts the measurement.

Top module: `ifw_discriminator`

## Requirements
- R1: While reset is high, and in the first cycle after it, both `res_valid` and `srch_stop` are 0.
- R2: A gate lasts (`tb_div`+1)·2^`samp_code` reference cycles. The first strobe after a control change arrives that many cycles plus one after the change is applied. Later strobes follow each other at exactly the gate length.
- R3: The expected count for a gate is (BASE + `ctr_code`)·2^`samp_code`. BASE is BASE_FM for `mode`=01, BASE_AM for `mode`=10 and BASE_UP for `mode`=11. Counted events are the cycles of the gate in which `if_pulse` is 1.
- R4: For `win_code` 1 to 5 the tolerance is 2^(`win_code`−1)·2^`samp_code` counts. The flag is 1 exactly when the measured count differs from the expected count by at most that tolerance. The bound is inclusive and applies on both sides.
- R5: With `win_code` 0, 6 or 7, every result reports `srch_stop`=0.
- R6: When `enable` is 0 or `mode` is 00, no strobe is produced and `srch_stop` is 0 from the next cycle on.
- R7: A change of any control input aborts the running gate without a result and starts a fresh gate in the following cycle.
- R8: `srch_stop` changes only in a cycle where `res_valid` is 1, except that entering standby clears it.
- R9: A count that runs past the preload, making the down-counter pass below zero, is rejected however large it grows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| if_pulse | input | 1 | IF event strobe, one high cycle per counted IF period |
| enable | input | 1 | 1 runs the measurement, 0 holds standby |
| mode | input | 2 | 01 FM, 10 AM, 11 AM up-conversion, 00 standby |
| tb_div | input | REF_DIV_W | Prescaler setting, base tick every `tb_div`+1 cycles |
| samp_code | input | SAMP_W | Gate length as 2^code base ticks |
| win_code | input | 3 | Tolerance window code, 1..5 valid |
| ctr_code | input | CF_W | Centre offset added to the per-tick base count |
| res_valid | output | 1 | One-cycle strobe at each completed gate |
| srch_stop | output | 1 | 1 when the last gate's count was inside the window |

## Verification
The bench builds the block with per-tick base counts of 40, 20 and 60 instead of the full-rate defaults. This keeps gates between a few dozen and a few thousand cycles long, so every mode, the deepest sample-time code, both window edges in each direction and a counter overrun past zero all fit in one short run. The IF rate is set by choosing the prescaler ratio against an input pulsing every cycle or every other cycle. This makes the measured count exact and independent of phase, which lets the scoreboard predict each flag and each strobe spacing exactly.

// File: rtl/ifw_pkg.sv
package ifw_pkg;

  // Mode field encoding; 00 parks the block in standby.
  typedef enum logic [1:0] {
    MD_OFF = 2'b00,
    MD_FM  = 2'b01,
    MD_AM  = 2'b10,
    MD_UPC = 2'b11
  } ifw_mode_e;

  // Window codes 1..5 are meaningful; all others never accept.
  function automatic logic win_code_ok(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd5);
  endfunction

endpackage

// File: rtl/ifw_gate_timer.sv
module ifw_gate_timer #(
  parameter int REF_DIV_W = 14,
  parameter int SAMP_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 restart,
  input  logic                 run,
  input  logic [REF_DIV_W-1:0] div,
  input  logic [SAMP_W-1:0]    samp,
  output logic                 gate_end
);

  // Largest gate is 2^(2^SAMP_W - 1) ticks, so the tick index needs this many bits.
  localparam int TICK_W = (1 << SAMP_W) - 1;

  logic [REF_DIV_W-1:0] pre_cnt;
  logic [TICK_W-1:0]    tick_cnt;
  logic [TICK_W-1:0]    tick_last;
  logic                 pre_hit;

  assign tick_last = (TICK_W'(1) << samp) - TICK_W'(1);
  assign pre_hit   = (pre_cnt == div);
  assign gate_end  = run && pre_hit && (tick_cnt == tick_last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_cnt  <= '0;
      tick_cnt <= '0;
    end else if (run) begin
      if (pre_hit) begin
        pre_cnt <= '0;
        if (tick_cnt == tick_last) tick_cnt <= '0;
        else                       tick_cnt <= tick_cnt + TICK_W'(1);
      end else begin
        pre_cnt <= pre_cnt + REF_DIV_W'(1);
      end
    end
  end

endmodule

// File: rtl/ifw_down_count.sv
module ifw_down_count #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] fin_val,
  output logic             fin_wrap
);

  logic [CNT_W-1:0] val;
  logic             wrapped;

  // Value and wrap state including this cycle's event, as seen at gate end.
  assign fin_val  = dec ? (val - CNT_W'(1)) : val;
  assign fin_wrap = wrapped || (dec && (val == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      val     <= '0;
      wrapped <= 1'b0;
    end else if (load) begin
      val     <= load_val;
      wrapped <= 1'b0;
    end else begin
      val     <= fin_val;
      wrapped <= fin_wrap;
    end
  end

endmodule

// File: rtl/ifw_window_judge.sv
module ifw_window_judge
  import ifw_pkg::*;
#(
  parameter int CNT_W  = 21,
  parameter int SAMP_W = 3
) (
  input  logic [CNT_W-1:0]  fin_val,
  input  logic              fin_wrap,
  input  logic [2:0]        win_code,
  input  logic [SAMP_W-1:0] samp,
  output logic              accept
);

  logic             code_ok;
  logic [CNT_W-1:0] span;

  // Preload carried +half, so a hit leaves a residue in [0, 2*half].
  assign code_ok = win_code_ok(win_code);
  assign span    = code_ok ? ((CNT_W'(2) << (win_code - 3'd1)) << samp) : '0;
  assign accept  = code_ok && !fin_wrap && (fin_val <= span);

endmodule

// File: rtl/ifw_discriminator.sv
module ifw_discriminator
  import ifw_pkg::*;
#(
  parameter int REF_DIV_W = 14,
  parameter int SAMP_W    = 3,
  parameter int CF_W      = 5,
  parameter int CNT_W     = 21,
  parameter int BASE_FM   = 1696,
  parameter int BASE_AM   = 448,
  parameter int BASE_UP   = 10688
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 if_pulse,
  input  logic                 enable,
  input  logic [1:0]           mode,
  input  logic [REF_DIV_W-1:0] tb_div,
  input  logic [SAMP_W-1:0]    samp_code,
  input  logic [2:0]           win_code,
  input  logic [CF_W-1:0]      ctr_code,
  output logic                 res_valid,
  output logic                 srch_stop
);

  // Registered copy of the controls the running gate was started with.
  logic                 en_q;
  logic [1:0]           md_q;
  logic [REF_DIV_W-1:0] div_q;
  logic [SAMP_W-1:0]    sp_q;
  logic [2:0]           wc_q;
  logic [CF_W-1:0]      cf_q;

  logic             changed, act_q, act_now;
  logic             gate_end, gate_done, load, dec, accept;
  logic [CNT_W-1:0] load_val, fin_val;
  logic             fin_wrap;

  function automatic logic [CNT_W-1:0] calc_preload(
    input logic [1:0]        md,
    input logic [SAMP_W-1:0] sp,
    input logic [2:0]        wc,
    input logic [CF_W-1:0]   cf
  );
    logic [CNT_W-1:0] base, nominal, half;
    case (ifw_mode_e'(md))
      MD_FM:   base = CNT_W'(BASE_FM);
      MD_AM:   base = CNT_W'(BASE_AM);
      default: base = CNT_W'(BASE_UP);
    endcase
    nominal = (base + CNT_W'(cf)) << sp;
    half    = win_code_ok(wc) ? ((CNT_W'(1) << (wc - 3'd1)) << sp) : '0;
    return nominal + half;
  endfunction

  assign changed = (enable != en_q) || (mode != md_q) || (tb_div != div_q) ||
                   (samp_code != sp_q) || (win_code != wc_q) || (ctr_code != cf_q);
  assign act_q   = en_q && (md_q != MD_OFF);
  assign act_now = enable && (mode != MD_OFF);

  assign gate_done = gate_end && !changed;
  assign load      = changed || gate_done;
  assign load_val  = changed ? calc_preload(mode, samp_code, win_code, ctr_code)
                             : calc_preload(md_q, sp_q, wc_q, cf_q);
  assign dec       = act_q && if_pulse && !changed;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      md_q  <= '0;
      div_q <= '0;
      sp_q  <= '0;
      wc_q  <= '0;
      cf_q  <= '0;
    end else begin
      en_q  <= enable;
      md_q  <= mode;
      div_q <= tb_div;
      sp_q  <= samp_code;
      wc_q  <= win_code;
      cf_q  <= ctr_code;
    end
  end

  ifw_gate_timer #(
    .REF_DIV_W (REF_DIV_W),
    .SAMP_W    (SAMP_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .restart  (changed),
    .run      (act_q),
    .div      (div_q),
    .samp     (sp_q),
    .gate_end (gate_end)
  );

  ifw_down_count #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .dec      (dec),
    .fin_val  (fin_val),
    .fin_wrap (fin_wrap)
  );

  ifw_window_judge #(
    .CNT_W  (CNT_W),
    .SAMP_W (SAMP_W)
  ) u_judge (
    .fin_val  (fin_val),
    .fin_wrap (fin_wrap),
    .win_code (wc_q),
    .samp     (sp_q),
    .accept   (accept)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      srch_stop <= 1'b0;
    end else begin
      res_valid <= gate_done;
      if (gate_done)
        srch_stop <= accept;
      else if (changed && !act_now)
        srch_stop <= 1'b0;
    end
  end

endmodule

// File: rtl/ifw_discriminator_chk.sv
module ifw_discriminator_chk #(
  parameter int REF_DIV_W = 14,
  parameter int SAMP_W    = 3,
  parameter int CF_W      = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 enable,
  input logic [1:0]           mode,
  input logic [REF_DIV_W-1:0] tb_div,
  input logic [SAMP_W-1:0]    samp_code,
  input logic [2:0]           win_code,
  input logic [CF_W-1:0]      ctr_code,
  input logic                 res_valid,
  input logic                 srch_stop
);

  logic [REF_DIV_W+SAMP_W+CF_W+5:0] ctl_prev;
  logic [REF_DIV_W+SAMP_W+CF_W+5:0] ctl_now;

  assign ctl_now = {enable, mode, tb_div, samp_code, win_code, ctr_code};

  always_ff @(posedge clk) begin
    if (rst) ctl_prev <= '0;
    else     ctl_prev <= ctl_now;
  end

  // R1: outputs are clear right after a reset cycle
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!res_valid && !srch_stop));

  // R5: unused window codes never accept
  p_unused_win_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !(($past(win_code) >= 3'd1) && ($past(win_code) <= 3'd5))) |-> !srch_stop);

  // R6: standby yields neither strobe nor flag
  p_standby_r6: assert property (@(posedge clk) disable iff (rst)
    (!enable || (mode == 2'b00)) |=> (!res_valid && !srch_stop));

  // R7: a control change suppresses the result of the gate it interrupts
  p_abort_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl_now != ctl_prev) |=> !res_valid);

  // R8: the flag can only rise together with a strobe
  p_flag_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(srch_stop) |-> res_valid);

endmodule

bind ifw_discriminator ifw_discriminator_chk #(
  .REF_DIV_W (REF_DIV_W),
  .SAMP_W    (SAMP_W),
  .CF_W      (CF_W)
) u_chk (.*);

// File: tb/sim_ifw_discriminator.sv
module sim_ifw_discriminator;

  localparam int BFM = 40;
  localparam int BAM = 20;
  localparam int BUP = 60;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       if_pulse = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [13:0] tb_div = '0;
  logic [2:0] samp_code = '0;
  logic [2:0] win_code = '0;
  logic [4:0] ctr_code = '0;
  logic       res_valid;
  logic       srch_stop;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int per = 1;
  int ph = 0;
  int t_apply = 0;
  int apply_id = 0;
  int seen_id = 0;
  int t_last = 0;
  int spurious = 0;
  int flag_glitch = 0;
  bit prev_flag = 1'b0;
  bit done = 1'b0;

  int    q_gap[$];
  bit    q_flag[$];
  string q_req[$];

  ifw_discriminator #(
    .BASE_FM (BFM),
    .BASE_AM (BAM),
    .BASE_UP (BUP)
  ) u0 (
    .clk       (clk),
    .rst       (rst),
    .if_pulse  (if_pulse),
    .enable    (enable),
    .mode      (mode),
    .tb_div    (tb_div),
    .samp_code (samp_code),
    .win_code  (win_code),
    .ctr_code  (ctr_code),
    .res_valid (res_valid),
    .srch_stop (srch_stop)
  );

  always #4ns clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // IF stimulus: one event every 'per' cycles, none when per is 0.
  always @(negedge clk) begin
    ph <= ph + 1;
    if_pulse <= (per == 0) ? 1'b0 : ((ph % per) == 0);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected results as strobes appear.
  always @(negedge clk) begin
    if (apply_id != seen_id) begin
      t_last  = t_apply;
      seen_id = apply_id;
    end
    if (!rst) begin
      if (res_valid) begin
        if (q_flag.size() == 0) begin
          spurious++;
          chk(1'b0, "R7", "unexpected result strobe", 1, 0);
        end else begin
          int    g;
          bit    f;
          string r;
          g = q_gap.pop_front();
          f = q_flag.pop_front();
          r = q_req.pop_front();
          chk(srch_stop == f, r, "search/stop flag", int'(srch_stop), int'(f));
          chk((cyc - t_last) == g, "R2", "strobe spacing", cyc - t_last, g);
        end
        t_last = cyc;
      end else if ((srch_stop != prev_flag) && enable && (mode != 2'b00)) begin
        flag_glitch++;
      end
      prev_flag = srch_stop;
    end
  end

  // Driver: apply a configuration and queue the results it must produce.
  task automatic run_cfg(input string req, input bit en, input logic [1:0] md,
                         input int ratio, input int sp, input int wc, input int cf,
                         input int pp, input int ngate);
    int base, len, cnt, expc, dev, half;
    bit acc;
    base = (md == 2'b01) ? BFM : ((md == 2'b10) ? BAM : BUP);
    len  = ratio << sp;
    cnt  = (pp == 0) ? 0 : (len / pp);
    expc = (base + cf) << sp;
    dev  = cnt - expc;
    if (dev < 0) dev = -dev;
    half = -1;
    if (wc >= 1 && wc <= 5) half = (1 << (wc - 1)) << sp;
    acc  = (half >= 0) && (dev <= half);
    @(negedge clk);
    enable    = en;
    mode      = md;
    tb_div    = 14'(ratio - 1);
    samp_code = 3'(sp);
    win_code  = 3'(wc);
    ctr_code  = 5'(cf);
    per       = pp;
    t_apply   = cyc;
    apply_id++;
    for (int i = 0; i < ngate; i++) begin
      q_gap.push_back((i == 0) ? len + 1 : len);
      q_flag.push_back(acc);
      q_req.push_back(req);
    end
    wait (q_flag.size() == 0);
  endtask

  task automatic idle_cfg(input bit en, input logic [1:0] md, input int ncyc);
    @(negedge clk);
    enable = en;
    mode   = md;
    repeat (ncyc) @(negedge clk);
    chk(srch_stop == 1'b0, "R6", "flag in standby", int'(srch_stop), 0);
    chk(res_valid == 1'b0, "R6", "strobe in standby", int'(res_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R1", "strobe during reset", int'(res_valid), 0);
    chk(srch_stop == 1'b0, "R1", "flag during reset", int'(srch_stop), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b0 && srch_stop == 1'b0, "R1", "outputs after reset",
        int'(res_valid) + int'(srch_stop), 0);

    // R3: FM, exact centre, three gates
    run_cfg("R3", 1'b1, 2'b01, 40, 0, 1, 0, 1, 3);
    // R4: FM window edges, both signs, sample code 1
    run_cfg("R4", 1'b1, 2'b01, 46, 1, 1, 5, 1, 2);
    run_cfg("R4", 1'b1, 2'b01, 47, 1, 1, 5, 1, 2);
    run_cfg("R4", 1'b1, 2'b01, 44, 1, 1, 5, 1, 2);
    run_cfg("R4", 1'b1, 2'b01, 43, 1, 1, 5, 1, 2);
    // R4: AM, wider window, sample code 2
    run_cfg("R4", 1'b1, 2'b10, 27, 2, 3, 3, 1, 2);
    run_cfg("R4", 1'b1, 2'b10, 28, 2, 3, 3, 1, 2);
    run_cfg("R4", 1'b1, 2'b10, 19, 2, 3, 3, 1, 2);
    run_cfg("R4", 1'b1, 2'b10, 18, 2, 3, 3, 1, 2);
    // R3: up-conversion, top centre code, widest window
    run_cfg("R3", 1'b1, 2'b11, 107, 0, 5, 31, 1, 2);
    run_cfg("R3", 1'b1, 2'b11, 108, 0, 5, 31, 1, 2);
    // R3: half-rate IF pulses
    run_cfg("R3", 1'b1, 2'b01, 80, 1, 2, 0, 2, 2);
    // R5: unused window codes
    run_cfg("R5", 1'b1, 2'b01, 40, 0, 0, 0, 1, 2);
    run_cfg("R5", 1'b1, 2'b01, 40, 0, 6, 0, 1, 2);
    run_cfg("R5", 1'b1, 2'b01, 40, 0, 7, 0, 1, 1);
    // R4: no IF activity at all
    run_cfg("R4", 1'b1, 2'b01, 40, 0, 1, 0, 0, 2);
    // R9: count runs far beyond preload
    run_cfg("R9", 1'b1, 2'b10, 200, 0, 1, 0, 1, 2);
    // R2: deepest sample-time code, accepted
    run_cfg("R2", 1'b1, 2'b10, 20, 7, 1, 0, 1, 2);
    // R6: standby via enable, then via mode 00 (flag was 1 before)
    idle_cfg(1'b0, 2'b10, 400);
    run_cfg("R3", 1'b1, 2'b01, 40, 0, 1, 0, 1, 1);
    idle_cfg(1'b1, 2'b00, 400);
    // R7: abort a long gate midway by changing the centre code
    run_cfg("R7", 1'b1, 2'b10, 20, 7, 1, 0, 1, 0);
    repeat (1000) @(negedge clk);
    run_cfg("R7", 1'b1, 2'b10, 21, 0, 1, 1, 1, 2);
    chk(spurious == 0, "R7", "aborted gates producing results", spurious, 0);
    chk(flag_glitch == 0, "R8", "flag changes without strobe", flag_glitch, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", q_flag.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule